// File: doc/BRIEF.md
# Software-Writable Register Field with Hardware Update

This block holds the storage and update logic for one field of a control or status register. Software reaches it through a small internal port: a request strobe with a write qualifier and write data. The stored value is always visible on the output, and that output also serves as the read data. Hardware can also load the field through a next-value input. A hardware enable gates that input, and a parameter sets the enable's polarity.

Parameters pick the field's behaviour. A plain field keeps whatever was last written. A plain field can instead be made self-clearing, so that a write shows on the output for one clock only. A sticky-bit field collects hardware events bit by bit, for interrupt status, and software clears bits by writing ones to them. A sticky-word field captures the first nonzero hardware value and holds it until software clears it. Two combinational strobes tell the surrounding logic when software touches the field and when software actually changes it. When hardware and software update the field in the same cycle, hardware has priority in every mode.

Top module: `sw_reg_field`

## Requirements
- R1: An asynchronous active-low reset forces the field to the RESET_VAL parameter at once; the strobes are 0 while reset is held.
- R2: The access strobe is 1 in exactly the cycles where the software request is 1, for reads and writes alike; the modify strobe is never 1 without it.
- R3: In plain mode a software write (request and write qualifier both 1) loads the write data at the next clock edge, and the modify strobe is 1 in that write's cycle, provided hardware is not loading in the same cycle.
- R4: In plain mode with the hardware enable present, the next-value input is loaded at the next clock edge whenever the enable is active (1 when HW_WE_HIGH is 1, 0 when it is 0); a software write in the same cycle is discarded and its modify strobe stays 0.
- R5: In self-clearing plain mode, the field returns to 0 one clock after any nonzero value, unless it is loaded again in that cycle. Without the hardware enable, the hardware input has no effect.
- R6: In sticky-bit mode each bit seen at 1 on the next-value input while the enable is active is 1 after the next edge and stays 1 after the input drops.
- R7: In sticky-bit mode a write clears exactly the field bits where the write data is 1 and leaves the others. A bit that hardware sets in the same cycle stays 1. The modify strobe is 1 for a write with nonzero data.
- R8: In sticky-word mode a zero field takes the next-value input at the next edge when that input is nonzero and the enable is active (always active when the enable is absent); while the field is nonzero, hardware values are ignored.
- R9: In sticky-word mode a write with nonzero data clears the field to 0 at the next edge, and the modify strobe pulses. If the hardware input is nonzero in that same cycle, the hardware value is loaded instead and the modify strobe stays 0.
- R10: A software read (request 1, write qualifier 0) never changes the stored value in plain mode without self-clearing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_req | input | 1 | Software access request, one cycle per access |
| sw_wr | input | 1 | Write qualifier for sw_req (1 write, 0 read) |
| sw_wdata | input | WIDTH | Software write data |
| hw_next | input | WIDTH | Hardware next value or event bits |
| hw_we | input | 1 | Hardware enable, polarity set by HW_WE_HIGH |
| field_q | output | WIDTH | Stored field value, also the read data |
| sw_acc | output | 1 | Software access strobe |
| sw_mod | output | 1 | Software modify strobe |

## Verification
The embedded properties assume that every input is a known value whenever reset is released. They also assume that inputs change only between clock edges, so the value sampled at an edge is the value that was applied for that cycle. The bench drives all inputs from the falling clock edge and holds them through the next rising edge. Starting during reset, it sweeps every combination of operation, enable level, write data and hardware value for a four-bit field in four configurations, so these assumptions hold throughout the run.

// File: rtl/sw_reg_field_pkg.sv
package sw_reg_field_pkg;
  typedef enum logic [1:0] {
    FIELD_PLAIN       = 2'd0,
    FIELD_STICKY_BITS = 2'd1,
    FIELD_STICKY_WORD = 2'd2
  } field_kind_e;
endpackage

// File: rtl/sw_reg_field_hw_gate.sv
module sw_reg_field_hw_gate #(
  parameter bit HW_WE_EN   = 1'b1,
  parameter bit HW_WE_HIGH = 1'b1,
  parameter bit ACT_ABSENT = 1'b0
) (
  input  logic hw_we,
  output logic hw_act
);
  // Enable present: honour the chosen polarity. Absent: fixed level.
  assign hw_act = HW_WE_EN ? (HW_WE_HIGH ? hw_we : ~hw_we) : ACT_ABSENT;
endmodule

// File: rtl/sw_reg_field_next.sv
module sw_reg_field_next
  import sw_reg_field_pkg::*;
#(
  parameter int          WIDTH = 4,
  parameter field_kind_e KIND  = FIELD_PLAIN,
  parameter bit          PULSE = 1'b0
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             wr_req,
  input  logic [WIDTH-1:0] wdata,
  input  logic [WIDTH-1:0] hw_val,
  input  logic             hw_act,
  output logic [WIDTH-1:0] nxt,
  output logic             mod
);
  logic [WIDTH-1:0] set_bits;
  logic [WIDTH-1:0] clr_bits;
  logic             hw_nz;
  logic             sw_clr;

  always_comb begin
    nxt      = cur;
    mod      = 1'b0;
    set_bits = hw_act ? hw_val : '0;
    clr_bits = wr_req ? wdata : '0;
    hw_nz    = hw_act && (hw_val != '0);
    sw_clr   = wr_req && (wdata != '0);
    case (KIND)
      FIELD_STICKY_BITS: begin
        // set wins over clear on the same bit
        nxt = (cur & ~clr_bits) | set_bits;
        mod = sw_clr;
      end
      FIELD_STICKY_WORD: begin
        if (sw_clr) begin
          nxt = hw_nz ? hw_val : '0;
          mod = ~hw_nz;
        end else if ((cur == '0) && hw_nz) begin
          nxt = hw_val;
        end
      end
      default: begin
        if (hw_act) begin
          nxt = hw_val;
        end else if (wr_req) begin
          nxt = wdata;
          mod = 1'b1;
        end else if (PULSE) begin
          nxt = '0;
        end
      end
    endcase
  end
endmodule

// File: rtl/sw_reg_field.sv
module sw_reg_field
  import sw_reg_field_pkg::*;
#(
  parameter int               WIDTH      = 4,
  parameter logic [WIDTH-1:0] RESET_VAL  = '0,
  parameter field_kind_e      KIND       = FIELD_PLAIN,
  parameter bit               PULSE      = 1'b0,
  parameter bit               HW_WE_EN   = 1'b1,
  parameter bit               HW_WE_HIGH = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_req,
  input  logic             sw_wr,
  input  logic [WIDTH-1:0] sw_wdata,
  input  logic [WIDTH-1:0] hw_next,
  input  logic             hw_we,
  output logic [WIDTH-1:0] field_q,
  output logic             sw_acc,
  output logic             sw_mod
);
  localparam bit IS_PLAIN   = (KIND == FIELD_PLAIN);
  localparam bit ACT_ABSENT = !IS_PLAIN;

  logic             wr_req;
  logic             hw_act;
  logic [WIDTH-1:0] q_nxt;
  logic             q_en;
  logic             mod_int;

  assign wr_req = sw_req & sw_wr;

  sw_reg_field_hw_gate #(
    .HW_WE_EN   (HW_WE_EN),
    .HW_WE_HIGH (HW_WE_HIGH),
    .ACT_ABSENT (ACT_ABSENT)
  ) i_gate (
    .hw_we  (hw_we),
    .hw_act (hw_act)
  );

  sw_reg_field_next #(
    .WIDTH (WIDTH),
    .KIND  (KIND),
    .PULSE (PULSE)
  ) i_next (
    .cur    (field_q),
    .wr_req (wr_req),
    .wdata  (sw_wdata),
    .hw_val (hw_next),
    .hw_act (hw_act),
    .nxt    (q_nxt),
    .mod    (mod_int)
  );

  assign q_en = (q_nxt != field_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      field_q <= RESET_VAL;
    end else if (q_en) begin
      field_q <= q_nxt;
    end
  end

  assign sw_acc = sw_req & rst_n;
  assign sw_mod = mod_int & rst_n;

  assert_mod_needs_acc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_mod |-> sw_acc);

  generate
    if (IS_PLAIN) begin : g_plain_chk
      assert_sw_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !hw_act) |=> field_q == $past(sw_wdata));
      assert_hw_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        hw_act |=> field_q == $past(hw_next));
      if (PULSE) begin : g_pulse_chk
        assert_self_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
          (field_q != '0 && !wr_req && !hw_act) |=> field_q == '0);
      end else begin : g_hold_chk
        assert_read_no_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
          (sw_req && !sw_wr && !hw_act) |=> $stable(field_q));
      end
    end else if (KIND == FIELD_STICKY_BITS) begin : g_bits_chk
      assert_bit_set_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hw_act |=> (field_q & $past(hw_next)) == $past(hw_next));
      assert_bit_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_req |=> (field_q & $past(field_q)) == $past(field_q));
    end else begin : g_word_chk
      assert_word_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (field_q != '0 && !(wr_req && sw_wdata != '0)) |=> $stable(field_q));
      assert_word_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && sw_wdata != '0 && !hw_act) |=> field_q == '0);
    end
  endgenerate
endmodule

// File: tb/test_sw_reg_field.sv
`timescale 1ns/1ps
module test_sw_reg_field;
  import sw_reg_field_pkg::*;

  logic       clk;
  logic       rst_n;
  logic       sw_req, sw_wr;
  logic [3:0] sw_wdata, hw_next;
  logic       we_a, we_c;
  logic [3:0] qa, qb, qc, qd;
  logic       acc_a, acc_b, acc_c, acc_d;
  logic       mod_a, mod_b, mod_c, mod_d;
  int         checks = 0;
  int         errors = 0;
  logic [3:0] ma, mb, mc, md;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // plain field, active-high enable, reset value 5
  sw_reg_field #(.WIDTH(4), .RESET_VAL(4'h5), .KIND(FIELD_PLAIN), .PULSE(1'b0),
                 .HW_WE_EN(1'b1), .HW_WE_HIGH(1'b1)) i_sw_reg_field (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .hw_next(hw_next), .hw_we(we_a), .field_q(qa), .sw_acc(acc_a), .sw_mod(mod_a));
  // self-clearing field, no hardware enable
  sw_reg_field #(.WIDTH(4), .RESET_VAL(4'h0), .KIND(FIELD_PLAIN), .PULSE(1'b1),
                 .HW_WE_EN(1'b0), .HW_WE_HIGH(1'b1)) i_sw_reg_field_pulse (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .hw_next(hw_next), .hw_we(we_a), .field_q(qb), .sw_acc(acc_b), .sw_mod(mod_b));
  // sticky bits, active-low enable
  sw_reg_field #(.WIDTH(4), .RESET_VAL(4'h0), .KIND(FIELD_STICKY_BITS), .PULSE(1'b0),
                 .HW_WE_EN(1'b1), .HW_WE_HIGH(1'b0)) i_sw_reg_field_bits (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .hw_next(hw_next), .hw_we(we_c), .field_q(qc), .sw_acc(acc_c), .sw_mod(mod_c));
  // sticky word, no enable
  sw_reg_field #(.WIDTH(4), .RESET_VAL(4'h0), .KIND(FIELD_STICKY_WORD), .PULSE(1'b0),
                 .HW_WE_EN(1'b0), .HW_WE_HIGH(1'b1)) i_sw_reg_field_word (
    .clk(clk), .rst_n(rst_n), .sw_req(sw_req), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .hw_next(hw_next), .hw_we(we_a), .field_q(qd), .sw_acc(acc_d), .sw_mod(mod_d));

  task automatic chk(input logic [3:0] got, input logic [3:0] exp,
                     input string tag, input string what);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic wr, hwa, hwc, hnz, wnz;
    logic ea, eb, ec, ed;
    rst_n = 1'b0; sw_req = 0; sw_wr = 0; sw_wdata = 0; hw_next = 0;
    we_a = 0; we_c = 1;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(qa, 4'h5, "R1", "plain reset");
    chk(qb, 4'h0, "R1", "pulse reset");
    chk(qc, 4'h0, "R1", "bits reset");
    chk(qd, 4'h0, "R1", "word reset");
    chk({3'b0, acc_a | mod_a}, 4'h0, "R1", "strobes in reset");
    rst_n = 1'b1;
    ma = 4'h5; mb = 0; mc = 0; md = 0;
    for (int op = 0; op < 3; op++) begin
      for (int we = 0; we < 2; we++) begin
        for (int wd = 0; wd < 16; wd++) begin
          for (int hn = 0; hn < 16; hn++) begin
            sw_req = (op != 0); sw_wr = (op == 2);
            sw_wdata = wd[3:0]; hw_next = hn[3:0];
            we_a = we[0]; we_c = we[0];
            #1;
            wr  = (op == 2);
            hwa = we[0];
            hwc = !we[0];
            hnz = (hn != 0);
            wnz = (wd != 0);
            // expected strobes
            ea = wr && !hwa;
            eb = wr;
            ec = wr && wnz;
            ed = wr && wnz && !hnz;
            chk({3'b0, acc_a}, {3'b0, op != 0}, "R2", "access strobe");
            chk({3'b0, acc_d}, {3'b0, op != 0}, "R2", "access strobe word");
            chk({3'b0, mod_a}, {3'b0, ea}, we[0] ? "R4" : "R3", "plain modify");
            chk({3'b0, mod_b}, {3'b0, eb}, "R5", "pulse modify");
            chk({3'b0, mod_c}, {3'b0, ec}, "R7", "bits modify");
            chk({3'b0, mod_d}, {3'b0, ed}, "R9", "word modify");
            // expected next state
            if (hwa) ma = hn[3:0]; else if (wr) ma = wd[3:0];
            mb = wr ? wd[3:0] : 4'h0;
            mc = (mc & ~(wr ? wd[3:0] : 4'h0)) | (hwc ? hn[3:0] : 4'h0);
            if (wr && wnz) md = hn[3:0];
            else if (md == 0) md = hn[3:0];
            @(negedge clk);
            chk(qa, ma, op == 1 ? "R10" : (we[0] ? "R4" : "R3"), "plain value");
            chk(qb, mb, "R5", "pulse value");
            chk(qc, mc, op == 2 ? "R7" : "R6", "bits value");
            chk(qd, md, op == 2 ? "R9" : "R8", "word value");
          end
        end
      end
    end
    // R1 asynchronous reset mid-cycle
    sw_req = 1; sw_wr = 1; sw_wdata = 4'hA; hw_next = 4'h3; we_a = 0; we_c = 0;
    @(negedge clk);
    sw_req = 0; sw_wr = 0;
    #1 rst_n = 1'b0;
    #0.5;
    chk(qa, 4'h5, "R1", "plain async reset");
    chk(qb, 4'h0, "R1", "pulse async reset");
    chk(qc, 4'h0, "R1", "bits async reset");
    chk(qd, 4'h0, "R1", "word async reset");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule